// File: doc/BRIEF.md
# Handshake-Paced Packet Byte Mover

This block carries packet bytes between a host processor and a microcontroller-side packet engine. The two sides meet at an 8-bit shift register and three active-low handshake lines held in a port-B style register. The host drives the transfer-in-progress and acknowledge lines by writing port B. The block drives the request line itself. A direction bit in an auxiliary control register selects the flow. In output mode the host writes a byte into the shift register and then changes a handshake line, and the block appends that byte to its receive buffer. In input mode every handshake change loads the next byte of a pending outgoing packet into the shift register, where the host can read it.

Each byte moved raises a shift-register interrupt flag. A read strobe from the host clears the flag. When the host releases transfer-in-progress, the block always raises the flag. If any bytes were collected, it also issues a one-cycle packet-complete pulse that carries the byte count. The consumer then reads the collected bytes back through a registered read port. Between transfers the request line follows the acknowledge line, and it is pulled low while outgoing bytes are still waiting. Bits do not move on a bit clock. A byte moves on any change of the two host lines, and a change is found by comparing each port-B write with the stored copy of the previous value.

Top module: `hsk_xfer_engine`

## Requirements
- R1: After reset, portb_q reads 0x38, which is every handshake line inactive and the request line high. shift_q reads 0, and sr_irq, pkt_done and pkt_len read 0.
- R2: portb_q bit 3 always shows the request line driven by the block. A host write to bit 3 has no effect on it. Bits 7..4 and 2..0 read back as they were last written through host_sel=0.
- R3: With control bit 4 set (host_sel=1), a port-B write that keeps bit 5 low and differs from the previous port-B value in bit 4 or bit 5 appends shift_q to the receive buffer. It also sets sr_irq, one cycle after the write.
- R4: Once DEPTH bytes have been collected, further output-direction bytes are dropped and sr_irq is not set for them.
- R5: With control bit 4 clear, each such write loads the next outgoing byte into shift_q and sets sr_irq. When no byte is left, shift_q and sr_irq do not change.
- R6: The write that loads the last outgoing byte drives the request line high.
- R7: A port-B write that makes bit 5 high after it was low sets sr_irq. If at least one byte was collected, pkt_done pulses for one cycle with pkt_len equal to the count, and the count returns to zero. rx_rdata shows the byte at rx_raddr one cycle later.
- R8: On an idle port-B write that is not an acknowledge change, the request line goes low if outgoing bytes remain unsent.
- R9: A port-B write that keeps bit 5 high, with bit 5 high before it, and that changes bit 4 copies the new bit 4 onto the request line and sets sr_irq.
- R10: tx_load restarts the outgoing packet with tx_len bytes and sets sr_irq. While idle, it drives the request line low when tx_len is nonzero.
- R11: host_sr_rd clears sr_irq unless a flag-setting event occurs in the same cycle.
- R12: A port-B write with bit 5 low that leaves bits 4 and 5 unchanged moves no byte and leaves sr_irq unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 2 | Register select: 0 port B, 1 control, 2 shift register |
| host_wdata | input | 8 | Host write data |
| host_sr_rd | input | 1 | Host read of shift register, clears sr_irq |
| portb_q | output | 8 | Port B readback with the request line on bit 3 |
| shift_q | output | 8 | Shift register contents |
| sr_irq | output | 1 | Shift-register interrupt flag |
| tx_wr | input | 1 | Outgoing buffer write strobe |
| tx_waddr | input | AW | Outgoing buffer write address |
| tx_wdata | input | 8 | Outgoing buffer write data |
| tx_load | input | 1 | Start a new outgoing packet |
| tx_len | input | CW | Outgoing packet length in bytes |
| rx_raddr | input | AW | Receive buffer read address |
| rx_rdata | output | 8 | Receive buffer read data, one cycle after address |
| pkt_done | output | 1 | One-cycle pulse: host packet complete |
| pkt_len | output | CW | Byte count of the completed packet |

## Verification
Every result is due one clock after the write or load that causes it: shift_q, the request bit in portb_q, sr_irq and the pkt_done pulse are all registered once. rx_rdata lags rx_raddr by one cycle. The bench drives each stimulus for exactly one cycle from a falling edge and samples on the next falling edge, right after the capturing rising edge. The packet monitor waits for the pulse in the same way and then walks the receive buffer one address per cycle. It compares each byte with the bytes that the driver queued.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
  typedef enum logic [1:0] {
    HS_PORTB = 2'd0,
    HS_CTRL  = 2'd1,
    HS_SHIFT = 2'd2,
    HS_SPARE = 2'd3
  } host_sel_e;

  localparam int REQ_POS = 3;
  localparam int ACK_POS = 4;
  localparam int TIP_POS = 5;
  localparam int DIR_POS = 4;
  localparam int BYTE_W  = 8;
  localparam logic [BYTE_W-1:0] LINES_RST = 8'h30;
endpackage

// File: rtl/hsk_ram.sv
module hsk_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hsk_line_track.sv
module hsk_line_track #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter int TIP = 5,
  parameter int ACK = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lines_q,
  output logic         tip_now,
  output logic         tip_prev,
  output logic         ack_now,
  output logic         tip_chg,
  output logic         ack_chg
);
  logic ack_prev;

  always_ff @(posedge clk) begin
    if (rst)     lines_q <= RST_VAL;
    else if (wr) lines_q <= wdata;
  end

  always_comb begin
    tip_prev = lines_q[TIP];
    ack_prev = lines_q[ACK];
    tip_now  = wr ? wdata[TIP] : lines_q[TIP];
    ack_now  = wr ? wdata[ACK] : lines_q[ACK];
    tip_chg  = wr && (tip_now != tip_prev);
    ack_chg  = wr && (ack_now != ack_prev);
  end
endmodule

// File: rtl/hsk_ctrl.sv
module hsk_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_b,
  input  logic          tip_now,
  input  logic          tip_prev,
  input  logic          ack_now,
  input  logic          tip_chg,
  input  logic          ack_chg,
  input  logic          dir_out,
  input  logic          sr_wr,
  input  logic [7:0]    sr_wdata,
  input  logic          sr_rd,
  input  logic          tx_load,
  input  logic [CW-1:0] tx_len,
  input  logic [7:0]    tx_byte,
  output logic [AW-1:0] tx_raddr,
  output logic          rx_we,
  output logic [AW-1:0] rx_waddr,
  output logic [7:0]    rx_wdata,
  output logic [7:0]    shift_q,
  output logic          req_n,
  output logic          irq,
  output logic          pkt_done,
  output logic [CW-1:0] pkt_len
);
  logic [CW-1:0] tx_idx, tx_idx_d, tx_cnt, tx_cnt_d, rx_cnt, rx_cnt_d;
  logic [CW-1:0] pkt_len_d;
  logic [7:0]    shift_d;
  logic          req_d, irq_set, pkt_d, moved;
  logic          tx_left, rx_room;

  assign tx_left = tx_idx < tx_cnt;
  assign rx_room = rx_cnt < CW'(DEPTH);
  assign moved   = tip_chg || ack_chg;

  always_comb begin
    tx_idx_d  = tx_idx;
    tx_cnt_d  = tx_cnt;
    rx_cnt_d  = rx_cnt;
    shift_d   = shift_q;
    req_d     = req_n;
    irq_set   = 1'b0;
    pkt_d     = 1'b0;
    pkt_len_d = pkt_len;
    rx_we     = 1'b0;
    rx_waddr  = rx_cnt[AW-1:0];
    rx_wdata  = shift_q;

    if (tx_load) begin
      // new outgoing packet: restart and re-evaluate the idle request
      tx_idx_d = '0;
      tx_cnt_d = tx_len;
      irq_set  = 1'b1;
      if (tip_prev && (tx_len != '0)) req_d = 1'b0;
    end else if (wr_b) begin
      if (!tip_now) begin
        if (dir_out) begin
          if (moved && rx_room) begin
            rx_we    = 1'b1;
            rx_cnt_d = rx_cnt + CW'(1);
            irq_set  = 1'b1;
          end
        end else if (moved && tx_left) begin
          shift_d  = tx_byte;
          tx_idx_d = tx_idx + CW'(1);
          irq_set  = 1'b1;
          if ((tx_idx + CW'(1)) >= tx_cnt) req_d = 1'b1;
        end
      end else begin
        if (tip_prev && ack_chg) begin
          req_d   = ack_now;
          irq_set = 1'b1;
        end else begin
          if (!tip_prev) begin
            irq_set = 1'b1;
            if (rx_cnt != '0) begin
              pkt_d     = 1'b1;
              pkt_len_d = rx_cnt;
            end
            rx_cnt_d = '0;
          end
          if (tx_left) req_d = 1'b0;
        end
      end
    end

    if (sr_wr) shift_d = sr_wdata;
  end

  assign tx_raddr = tx_idx_d[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_idx   <= '0;
      tx_cnt   <= '0;
      rx_cnt   <= '0;
      shift_q  <= '0;
      req_n    <= 1'b1;
      irq      <= 1'b0;
      pkt_done <= 1'b0;
      pkt_len  <= '0;
    end else begin
      tx_idx   <= tx_idx_d;
      tx_cnt   <= tx_cnt_d;
      rx_cnt   <= rx_cnt_d;
      shift_q  <= shift_d;
      req_n    <= req_d;
      pkt_done <= pkt_d;
      pkt_len  <= pkt_len_d;
      if (irq_set)    irq <= 1'b1;
      else if (sr_rd) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/hsk_xfer_engine.sv
module hsk_xfer_engine
  import hsk_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr,
  input  logic [1:0]    host_sel,
  input  logic [7:0]    host_wdata,
  input  logic          host_sr_rd,
  output logic [7:0]    portb_q,
  output logic [7:0]    shift_q,
  output logic          sr_irq,
  input  logic          tx_wr,
  input  logic [AW-1:0] tx_waddr,
  input  logic [7:0]    tx_wdata,
  input  logic          tx_load,
  input  logic [CW-1:0] tx_len,
  input  logic [AW-1:0] rx_raddr,
  output logic [7:0]    rx_rdata,
  output logic          pkt_done,
  output logic [CW-1:0] pkt_len
);
  logic          wr_b, wr_c, wr_s;
  logic          dir_out;
  logic [7:0]    lines_q;
  logic          tip_now, tip_prev, ack_now, tip_chg, ack_chg;
  logic          req_n;
  logic [AW-1:0] tx_raddr, rx_waddr;
  logic [7:0]    tx_byte, rx_wdata;
  logic          rx_we;
  logic          unused_bit3;

  assign wr_b = host_wr && (host_sel == HS_PORTB);
  assign wr_c = host_wr && (host_sel == HS_CTRL);
  assign wr_s = host_wr && (host_sel == HS_SHIFT);

  always_ff @(posedge clk) begin
    if (rst)       dir_out <= 1'b0;
    else if (wr_c) dir_out <= host_wdata[DIR_POS];
  end

  hsk_line_track #(
    .W(BYTE_W), .RST_VAL(LINES_RST), .TIP(TIP_POS), .ACK(ACK_POS)
  ) u_lines (
    .clk(clk), .rst(rst), .wr(wr_b), .wdata(host_wdata),
    .lines_q(lines_q), .tip_now(tip_now), .tip_prev(tip_prev),
    .ack_now(ack_now), .tip_chg(tip_chg), .ack_chg(ack_chg)
  );

  hsk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .wr_b(wr_b),
    .tip_now(tip_now), .tip_prev(tip_prev), .ack_now(ack_now),
    .tip_chg(tip_chg), .ack_chg(ack_chg), .dir_out(dir_out),
    .sr_wr(wr_s), .sr_wdata(host_wdata), .sr_rd(host_sr_rd),
    .tx_load(tx_load), .tx_len(tx_len), .tx_byte(tx_byte),
    .tx_raddr(tx_raddr), .rx_we(rx_we), .rx_waddr(rx_waddr),
    .rx_wdata(rx_wdata), .shift_q(shift_q), .req_n(req_n),
    .irq(sr_irq), .pkt_done(pkt_done), .pkt_len(pkt_len)
  );

  hsk_ram #(.DW(BYTE_W), .DEPTH(DEPTH)) u_txbuf (
    .clk(clk), .we(tx_wr), .waddr(tx_waddr), .wdata(tx_wdata),
    .raddr(tx_raddr), .rdata(tx_byte)
  );

  hsk_ram #(.DW(BYTE_W), .DEPTH(DEPTH)) u_rxbuf (
    .clk(clk), .we(rx_we), .waddr(rx_waddr), .wdata(rx_wdata),
    .raddr(rx_raddr), .rdata(rx_rdata)
  );

  assign unused_bit3 = lines_q[REQ_POS];
  assign portb_q = {lines_q[7:REQ_POS+1], req_n, lines_q[REQ_POS-1:0]};
endmodule

// File: rtl/hsk_xfer_chk.sv
module hsk_xfer_chk
  import hsk_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          host_wr,
  input logic [1:0]    host_sel,
  input logic [7:0]    host_wdata,
  input logic          host_sr_rd,
  input logic          tx_load,
  input logic [7:0]    portb_q,
  input logic [7:0]    shift_q,
  input logic          sr_irq,
  input logic          pkt_done,
  input logic [CW-1:0] pkt_len
);
  logic pb_wr;
  logic unused_wdata;
  assign pb_wr = host_wr && (host_sel == HS_PORTB);
  assign unused_wdata = ^{host_wdata[7:6], host_wdata[4:0]};

  // R7
  pkt_len_range_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_done |-> (pkt_len != '0) && (pkt_len <= CW'(DEPTH)));

  // R7
  pkt_after_release_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_done |-> $past(pb_wr && host_wdata[TIP_POS]));

  // R7
  pkt_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_done |=> !pkt_done);

  // R3
  irq_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sr_irq) |-> $past(pb_wr || tx_load));

  // R11
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (host_sr_rd && !pb_wr && !tx_load) |=> !sr_irq);

  // R2
  portb_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!pb_wr && !tx_load) |=> $stable(portb_q));

  // R5
  shift_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !host_wr |=> $stable(shift_q));
endmodule

bind hsk_xfer_engine hsk_xfer_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_sel(host_sel),
  .host_wdata(host_wdata), .host_sr_rd(host_sr_rd), .tx_load(tx_load),
  .portb_q(portb_q), .shift_q(shift_q), .sr_irq(sr_irq),
  .pkt_done(pkt_done), .pkt_len(pkt_len)
);

// File: tb/sim_hsk_xfer_engine.sv
`timescale 1ns/1ps
module sim_hsk_xfer_engine;
  localparam int D  = 16;
  localparam int AW = $clog2(D);
  localparam int CW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_wr = 1'b0;
  logic [1:0]    host_sel = 2'd0;
  logic [7:0]    host_wdata = 8'h00;
  logic          host_sr_rd = 1'b0;
  logic [7:0]    portb_q, shift_q, rx_rdata;
  logic          sr_irq, pkt_done;
  logic          tx_wr = 1'b0;
  logic [AW-1:0] tx_waddr = '0;
  logic [7:0]    tx_wdata = 8'h00;
  logic          tx_load = 1'b0;
  logic [CW-1:0] tx_len = '0;
  logic [AW-1:0] rx_raddr = '0;
  logic [CW-1:0] pkt_len;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_bytes[$];
  int         exp_lens[$];

  always #2.5 clk = ~clk;

  hsk_xfer_engine #(.DEPTH(D)) u0 (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_sr_rd(host_sr_rd), .portb_q(portb_q),
    .shift_q(shift_q), .sr_irq(sr_irq), .tx_wr(tx_wr), .tx_waddr(tx_waddr),
    .tx_wdata(tx_wdata), .tx_load(tx_load), .tx_len(tx_len),
    .rx_raddr(rx_raddr), .rx_rdata(rx_rdata), .pkt_done(pkt_done),
    .pkt_len(pkt_len)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    host_wr = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic clr();
    host_sr_rd = 1'b1;
    @(negedge clk);
    host_sr_rd = 1'b0;
  endtask

  task automatic txw(input int a, input logic [7:0] d);
    tx_wr = 1'b1; tx_waddr = AW'(a); tx_wdata = d;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic load(input int n);
    tx_load = 1'b1; tx_len = CW'(n);
    @(negedge clk);
    tx_load = 1'b0;
  endtask

  // scoreboard monitor: pops expected packets as the design reports them
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && pkt_done) begin
        if (exp_lens.size() == 0) begin
          chk("R7 unexpected packet", 32'(pkt_len), 32'h0);
        end else begin
          int n;
          n = exp_lens.pop_front();
          chk("R7 packet length", 32'(pkt_len), 32'(n));
          for (int i = 0; i < n; i++) begin
            rx_raddr = AW'(i);
            @(negedge clk);
            chk("R7 packet byte", 32'(rx_rdata), 32'(exp_bytes.pop_front()));
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 portb", 32'(portb_q), 32'h38);
    chk("R1 shift", 32'(shift_q), 32'h0);
    chk("R1 irq", 32'(sr_irq), 32'h0);
    chk("R1 pkt", 32'({pkt_done, pkt_len}), 32'h0);

    // output direction, three bytes
    wr(2'd1, 8'h10);
    wr(2'd2, 8'hA1);
    chk("R3 shift written", 32'(shift_q), 32'hA1);
    wr(2'd0, 8'h10);
    chk("R3 irq on first byte", 32'(sr_irq), 32'h1);
    chk("R2 portb readback", 32'(portb_q), 32'h18);
    clr();
    chk("R11 irq cleared", 32'(sr_irq), 32'h0);
    wr(2'd2, 8'hB2);
    wr(2'd0, 8'h00);
    chk("R3 irq on second byte", 32'(sr_irq), 32'h1);
    clr();
    wr(2'd2, 8'hC3);
    wr(2'd0, 8'h10);
    clr();
    wr(2'd0, 8'h10);
    chk("R12 no change no irq", 32'(sr_irq), 32'h0);
    exp_lens.push_back(3);
    exp_bytes.push_back(8'hA1); exp_bytes.push_back(8'hB2); exp_bytes.push_back(8'hC3);
    wr(2'd0, 8'h30);
    chk("R7 irq at release", 32'(sr_irq), 32'h1);
    repeat (8) @(negedge clk);

    // idle echo of acknowledge
    clr();
    wr(2'd0, 8'h20);
    chk("R9 req follows ack low", 32'(portb_q), 32'h20);
    chk("R9 irq on echo", 32'(sr_irq), 32'h1);
    wr(2'd0, 8'h28);
    chk("R2 host bit3 ignored", 32'(portb_q), 32'h20);
    wr(2'd0, 8'h30);
    chk("R9 req follows ack high", 32'(portb_q), 32'h38);

    // input direction, three bytes
    wr(2'd1, 8'h00);
    txw(0, 8'h11); txw(1, 8'h22); txw(2, 8'h33);
    clr();
    load(3);
    chk("R10 req low after load", 32'(portb_q), 32'h30);
    chk("R10 irq after load", 32'(sr_irq), 32'h1);
    clr();
    wr(2'd0, 8'h10);
    chk("R5 first byte", 32'(shift_q), 32'h11);
    chk("R5 irq", 32'(sr_irq), 32'h1);
    chk("R6 req held low", 32'(portb_q), 32'h10);
    wr(2'd0, 8'h00);
    chk("R5 second byte", 32'(shift_q), 32'h22);
    wr(2'd0, 8'h10);
    chk("R5 third byte", 32'(shift_q), 32'h33);
    chk("R6 req high after last", 32'(portb_q), 32'h18);
    clr();
    wr(2'd0, 8'h00);
    chk("R5 nothing left shift", 32'(shift_q), 32'h33);
    chk("R5 nothing left irq", 32'(sr_irq), 32'h0);
    wr(2'd0, 8'h30);
    chk("R7 irq without bytes", 32'(sr_irq), 32'h1);
    chk("R7 no packet when empty", 32'(pkt_done), 32'h0);
    chk("R8 req stays high", 32'(portb_q), 32'h38);

    // release with bytes pending
    txw(0, 8'h44); txw(1, 8'h55);
    load(2);
    wr(2'd0, 8'h10);
    chk("R5 partial byte", 32'(shift_q), 32'h44);
    wr(2'd0, 8'h30);
    chk("R8 req low while pending", 32'(portb_q), 32'h30);
    wr(2'd0, 8'h10);
    chk("R6 req high on drain", 32'(portb_q), 32'h18);
    wr(2'd0, 8'h30);

    // output direction overflow
    wr(2'd1, 8'h10);
    for (int k = 0; k < D + 2; k++) begin
      logic [7:0] b;
      b = 8'((k * 7) + 1);
      if (k < D) exp_bytes.push_back(b);
      wr(2'd2, b);
      if (k == D) clr();
      wr(2'd0, (k % 2 == 0) ? 8'h10 : 8'h00);
      if (k == D) chk("R4 dropped byte no irq", 32'(sr_irq), 32'h0);
    end
    exp_lens.push_back(D);
    wr(2'd0, 8'h30);
    repeat (2 * D + 10) @(negedge clk);
    chk("R7 all packets seen", 32'(exp_lens.size()), 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule